// File: doc/BRIEF.md
# System-Management Interrupt Enable and Source Gating

This block holds the 32-bit control word that decides which platform events may raise a system-management interrupt. Each event input is qualified by its own enable bit. The qualified events are ORed together and registered, and the result drives a single active-low interrupt line. Software writes the word through a plain write strobe and data bus. The stored value can be read back at any time on a read bus.

Some enable bits do more than gate a source:
- One bit starts a software countdown. When the countdown expires it flags a status pulse and raises the interrupt.
- One bit never holds a value. Writing a 1 to it fires a one-cycle pulse that sets the global status feeding the ACPI SCI path.
- The watchdog enable can be frozen by a lock input.
- A reroute flag lets NMI-derived events bypass the watchdog enable.
- An I/O trap enable claims accesses to the two embedded-controller ports. A claimed access is kept off the downstream path.

Top module: `smi_enable_ctrl`

## Requirements
- R1: After reset the read value is 0, `smi_n_o` is 1, and `glb_set_o` and `tmr_sts_o` are 0.
- R2: Only bits 14 (periodic), 13 (watchdog), 11 (I/O trap), 6 (software timer) and 5 (APM command) store the written value. Every other bit, including reserved bits 12 and 10:8, reads 0 and ignores writes.
- R3: While `en_lock_i` is 1, a write leaves bit 13 unchanged. The other bits are still written.
- R4: With bit 14 set, a high `periodic_sts_i` drives `smi_n_o` low in the following cycle.
- R5: With bit 13 set, `wdog_evt_i` drives `smi_n_o` low in the following cycle. With bit 13 clear, it has no effect.
- R6: `nmi_evt_i` drives `smi_n_o` low in the following cycle when bit 13 or `nmi_reroute_i` is 1.
- R7: When bit 11 is set, an access with `io_valid_i` high to address 0x62 or 0x66 raises `io_trap_o` and lowers `io_fwd_o` in the same cycle, and drives `smi_n_o` low in the following cycle. Any other access is forwarded.
- R8: Writing 1 to bit 7 gives a one-cycle `glb_set_o` pulse in the cycle after the write. Bit 7 always reads 0. Writing 0 to it does nothing.
- R9: `tmr_sts_o` pulses exactly P cycles after the write that sets bit 6. P is `TMR_P0` when `rate_sel_i` is 0 and `TMR_P1` when it is 1. The pulse repeats every P cycles while bit 6 stays set. Each pulse drives `smi_n_o` low in the following cycle.
- R10: Clearing bit 6 before expiry resets the countdown, and no `tmr_sts_o` pulse follows.
- R11: With bit 5 set, `apm_wr_i` drives `smi_n_o` low in the following cycle. With bit 5 clear, it has no effect.
- R12: `smi_n_o` is a registered, active-low OR of all qualified sources. It is 1 in any cycle that follows a cycle with no qualified source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current control word |
| en_lock_i | input | 1 | Freezes the watchdog enable bit |
| nmi_reroute_i | input | 1 | Lets NMI events bypass the watchdog enable |
| periodic_sts_i | input | 1 | Periodic status flag |
| wdog_evt_i | input | 1 | Watchdog event |
| nmi_evt_i | input | 1 | NMI-derived event |
| io_valid_i | input | 1 | I/O access present |
| io_addr_i | input | IO_ADDR_W | I/O access address |
| apm_wr_i | input | 1 | Write to the APM command port |
| rate_sel_i | input | 1 | Software timer period select |
| io_trap_o | output | 1 | Access claimed by the trap |
| io_fwd_o | output | 1 | Access forwarded downstream |
| glb_set_o | output | 1 | Global status set pulse |
| tmr_sts_o | output | 1 | Software timer expiry pulse |
| smi_n_o | output | 1 | Active-low interrupt |

## Verification
The bench checks the lock against a write that tries to flip the watchdog bit. A broken lock would let software disable watchdog interrupts.

It checks the first timer expiry at exactly P cycles. A counter off by one, or one that keeps running after it should have reset, would fire early, late, or after a cancel.

It checks that the NMI bypass still raises the interrupt with the watchdog enable clear, and that bit 7 reads back as 0 after a write of 1. A design that stored bit 7 would report a stale value and miss the pulse semantics.

Random writes cover reserved bits alongside the writable ones, against a cycle-accurate model kept in bench functions.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int REG_W    = 32;
    localparam int B_PER    = 14;
    localparam int B_WDOG   = 13;
    localparam int B_TRAP   = 11;
    localparam int B_GLB    = 7;
    localparam int B_TMR    = 6;
    localparam int B_APM    = 5;
    localparam logic [REG_W-1:0] STORE_MASK = 32'h0000_6860;
    localparam int NSRC     = 6;

    typedef struct packed {
        logic per_en;
        logic wdog_en;
        logic trap_en;
        logic tmr_en;
        logic apm_en;
    } smi_en_t;
endpackage

// File: rtl/smi_en_regs.sv
module smi_en_regs
    import smi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             lock_i,
    output smi_en_t          en_o,
    output logic [REG_W-1:0] rd_data_o,
    output logic             glb_set_o
);
    typedef struct packed {
        smi_en_t en;
        logic    glb;
    } regs_t;

    regs_t q, d;
    logic  unused_wr;

    assign unused_wr = ^(wr_data_i & ~(STORE_MASK | (REG_W'(1) << B_GLB)));

    always_comb begin
        d     = q;
        d.glb = 1'b0;
        if (wr_en_i) begin
            d.en.per_en  = wr_data_i[B_PER];
            d.en.trap_en = wr_data_i[B_TRAP];
            d.en.tmr_en  = wr_data_i[B_TMR];
            d.en.apm_en  = wr_data_i[B_APM];
            d.glb        = wr_data_i[B_GLB];
            if (!lock_i) begin
                d.en.wdog_en = wr_data_i[B_WDOG];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data_o         = '0;
        rd_data_o[B_PER]  = q.en.per_en;
        rd_data_o[B_WDOG] = q.en.wdog_en;
        rd_data_o[B_TRAP] = q.en.trap_en;
        rd_data_o[B_TMR]  = q.en.tmr_en;
        rd_data_o[B_APM]  = q.en.apm_en;
    end

    assign en_o      = q.en;
    assign glb_set_o = q.glb;
endmodule

// File: rtl/smi_sw_timer.sv
module smi_sw_timer #(
    parameter int TMR_P0 = 48,
    parameter int TMR_P1 = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic rate_sel_i,
    output logic expire_o
);
    localparam int PMAX  = (TMR_P0 > TMR_P1) ? TMR_P0 : TMR_P1;
    localparam int CNT_W = (PMAX > 2) ? $clog2(PMAX) : 1;
    localparam logic [CNT_W-1:0] LIM0 = CNT_W'(TMR_P0 - 1);
    localparam logic [CNT_W-1:0] LIM1 = CNT_W'(TMR_P1 - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expire;
    } tmr_t;

    tmr_t             q, d;
    logic [CNT_W-1:0] lim;
    logic             hit;

    always_comb begin
        lim      = rate_sel_i ? LIM1 : LIM0;
        hit      = en_i && (q.cnt >= lim);
        d        = q;
        d.expire = hit;
        if (!en_i)    d.cnt = '0;
        else if (hit) d.cnt = '0;
        else          d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expire_o = q.expire;
endmodule

// File: rtl/smi_src_gate.sv
module smi_src_gate
    import smi_pkg::*;
#(
    parameter int                 IO_ADDR_W = 16,
    parameter logic [IO_ADDR_W-1:0] PORT_A  = 'h62,
    parameter logic [IO_ADDR_W-1:0] PORT_B  = 'h66
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  smi_en_t              en_i,
    input  logic                 reroute_i,
    input  logic                 periodic_i,
    input  logic                 wdog_i,
    input  logic                 nmi_i,
    input  logic                 io_valid_i,
    input  logic [IO_ADDR_W-1:0] io_addr_i,
    input  logic                 apm_i,
    input  logic                 tmr_fire_i,
    output logic                 io_trap_o,
    output logic                 io_fwd_o,
    output logic                 smi_n_o
);
    typedef struct packed {
        logic smi_n;
    } gate_t;

    gate_t           q, d;
    logic [NSRC-1:0] raw, gate, hot;
    logic            addr_hit;

    always_comb begin
        addr_hit  = (io_addr_i == PORT_A) || (io_addr_i == PORT_B);
        io_trap_o = io_valid_i && en_i.trap_en && addr_hit;
        io_fwd_o  = io_valid_i && !io_trap_o;
        raw  = {periodic_i, wdog_i, nmi_i, io_trap_o, apm_i, tmr_fire_i};
        gate = {en_i.per_en, en_i.wdog_en, en_i.wdog_en | reroute_i,
                1'b1, en_i.apm_en, 1'b1};
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_qual
        assign hot[i] = raw[i] & gate[i];
    end

    always_comb begin
        d       = q;
        d.smi_n = ~(|hot);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{smi_n: 1'b1};
        else        q <= d;
    end

    assign smi_n_o = q.smi_n;
endmodule

// File: rtl/smi_enable_ctrl.sv
module smi_enable_ctrl
    import smi_pkg::*;
#(
    parameter int IO_ADDR_W = 16,
    parameter int TMR_P0    = 48,
    parameter int TMR_P1    = 160
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [REG_W-1:0]     wr_data_i,
    output logic [REG_W-1:0]     rd_data_o,
    input  logic                 en_lock_i,
    input  logic                 nmi_reroute_i,
    input  logic                 periodic_sts_i,
    input  logic                 wdog_evt_i,
    input  logic                 nmi_evt_i,
    input  logic                 io_valid_i,
    input  logic [IO_ADDR_W-1:0] io_addr_i,
    input  logic                 apm_wr_i,
    input  logic                 rate_sel_i,
    output logic                 io_trap_o,
    output logic                 io_fwd_o,
    output logic                 glb_set_o,
    output logic                 tmr_sts_o,
    output logic                 smi_n_o
);
    smi_en_t en;
    logic    expire;

    smi_en_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .lock_i    (en_lock_i),
        .en_o      (en),
        .rd_data_o (rd_data_o),
        .glb_set_o (glb_set_o)
    );

    smi_sw_timer #(.TMR_P0(TMR_P0), .TMR_P1(TMR_P1)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en.tmr_en),
        .rate_sel_i (rate_sel_i),
        .expire_o   (expire)
    );

    assign tmr_sts_o = expire & en.tmr_en;

    smi_src_gate #(.IO_ADDR_W(IO_ADDR_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .reroute_i  (nmi_reroute_i),
        .periodic_i (periodic_sts_i),
        .wdog_i     (wdog_evt_i),
        .nmi_i      (nmi_evt_i),
        .io_valid_i (io_valid_i),
        .io_addr_i  (io_addr_i),
        .apm_i      (apm_wr_i),
        .tmr_fire_i (tmr_sts_o),
        .io_trap_o  (io_trap_o),
        .io_fwd_o   (io_fwd_o),
        .smi_n_o    (smi_n_o)
    );
endmodule

// File: rtl/smi_enable_chk.sv
module smi_enable_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en_i,
    input logic [31:0] wr_data_i,
    input logic [31:0] rd_data_o,
    input logic        en_lock_i,
    input logic        nmi_reroute_i,
    input logic        periodic_sts_i,
    input logic        nmi_evt_i,
    input logic        apm_wr_i,
    input logic        io_trap_o,
    input logic        io_fwd_o,
    input logic        glb_set_o,
    input logic        tmr_sts_o,
    input logic        smi_n_o
);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o & ~32'h0000_6860) == 32'h0);

    assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && en_lock_i) |=> (rd_data_o[13] == $past(rd_data_o[13])));

    assert_periodic_smi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (periodic_sts_i && rd_data_o[14]) |=> !smi_n_o);

    assert_nmi_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_evt_i && (rd_data_o[13] || nmi_reroute_i)) |=> !smi_n_o);

    assert_trap_no_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        io_trap_o |-> !io_fwd_o);

    assert_glb_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[7]) |=> glb_set_o);

    assert_tmr_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data_o[6] |=> !tmr_sts_o);

    assert_apm_smi_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (apm_wr_i && rd_data_o[5]) |=> !smi_n_o);
endmodule

bind smi_enable_ctrl smi_enable_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .rd_data_o      (rd_data_o),
    .en_lock_i      (en_lock_i),
    .nmi_reroute_i  (nmi_reroute_i),
    .periodic_sts_i (periodic_sts_i),
    .nmi_evt_i      (nmi_evt_i),
    .apm_wr_i       (apm_wr_i),
    .io_trap_o      (io_trap_o),
    .io_fwd_o       (io_fwd_o),
    .glb_set_o      (glb_set_o),
    .tmr_sts_o      (tmr_sts_o),
    .smi_n_o        (smi_n_o)
);

// File: tb/smi_enable_ctrl_tb.sv
module smi_enable_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P0 = 48;
    localparam int P1 = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        lock = 1'b0, reroute = 1'b0, per = 1'b0, wdog = 1'b0, nmi = 1'b0;
    logic        io_v = 1'b0, apm = 1'b0, rsel = 1'b0;
    logic [15:0] io_a = '0;
    logic        trap, fwd, glb, tmr, smi_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_reg = '0;
    int          m_cnt = 0;
    bit          m_exp = 0, m_smi_n = 1, m_glb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_enable_ctrl #(.TMR_P0(P0), .TMR_P1(P1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .en_lock_i(lock), .nmi_reroute_i(reroute),
        .periodic_sts_i(per), .wdog_evt_i(wdog), .nmi_evt_i(nmi),
        .io_valid_i(io_v), .io_addr_i(io_a), .apm_wr_i(apm), .rate_sel_i(rsel),
        .io_trap_o(trap), .io_fwd_o(fwd), .glb_set_o(glb), .tmr_sts_o(tmr),
        .smi_n_o(smi_n));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int period(bit rs);
        return rs ? P1 : P0;
    endfunction

    function automatic bit exp_trap();
        return io_v && m_reg[11] && (io_a == 16'h62 || io_a == 16'h66);
    endfunction

    // One clock: called at a negedge with inputs set; returns at the next negedge.
    task automatic tick();
        bit src, hit;
        #1;
        chk("R7 trap", {31'b0, trap}, {31'b0, exp_trap()});
        chk("R7 fwd", {31'b0, fwd}, {31'b0, io_v && !exp_trap()});
        src = (per && m_reg[14]) || (wdog && m_reg[13]) ||
              (nmi && (m_reg[13] || reroute)) || exp_trap() ||
              (apm && m_reg[5]) || (m_exp && m_reg[6]);
        m_smi_n = !src;
        m_glb   = wr_en && wr_data[7];
        hit     = m_reg[6] && (m_cnt >= period(rsel) - 1);
        m_cnt   = (!m_reg[6] || hit) ? 0 : m_cnt + 1;
        m_exp   = hit;
        if (wr_en) begin
            logic [31:0] keep13;
            keep13 = m_reg & 32'h2000;
            m_reg  = wr_data & 32'h6860;
            if (lock) m_reg = (m_reg & ~32'h2000) | keep13;
        end
        @(posedge clk);
        #1;
        chk("R2 readback", rd_data, m_reg);
        chk("R12 smi_n", {31'b0, smi_n}, {31'b0, m_smi_n});
        chk("R8 glb", {31'b0, glb}, {31'b0, m_glb});
        chk("R9 tmr", {31'b0, tmr}, {31'b0, m_exp && m_reg[6]});
        @(negedge clk);
    endtask

    task automatic wreg(logic [31:0] v, bit lk);
        wr_en = 1; wr_data = v; lock = lk;
        tick();
        wr_en = 0; wr_data = '0; lock = 0;
    endtask

    task automatic clear_events();
        per = 0; wdog = 0; nmi = 0; io_v = 0; apm = 0; reroute = 0; io_a = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int first;
        bit seen;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd", rd_data, 32'h0);
        chk("R1 smi_n", {31'b0, smi_n}, 32'h1);
        chk("R1 glb", {31'b0, glb}, 32'h0);
        chk("R1 tmr", {31'b0, tmr}, 32'h0);

        // R2 / R8: all ones stores only the writable bits; bit 7 pulses and reads 0
        wreg(32'hFFFF_FFFF, 0);
        chk("R2 mask", rd_data, 32'h0000_6860);
        chk("R8 pulse", {31'b0, glb}, 32'h1);
        // R3: locked write cannot clear bit 13
        wreg(32'h0, 1);
        chk("R3 lock keep", rd_data, 32'h0000_2000);
        wreg(32'h0, 0);
        wreg(32'h0000_2000, 1);
        chk("R3 lock set blocked", rd_data, 32'h0);
        // R8: writing 0 to bit 7 does nothing
        wreg(32'h0, 0);
        chk("R8 zero", {31'b0, glb}, 32'h0);

        // R4 periodic
        wreg(32'h0000_4000, 0);
        per = 1; tick(); per = 0;
        chk("R4 periodic", {31'b0, smi_n}, 32'h0);
        // R5 watchdog enabled and blocked
        wreg(32'h0000_2000, 0);
        wdog = 1; tick(); wdog = 0;
        chk("R5 wdog on", {31'b0, smi_n}, 32'h0);
        wreg(32'h0, 0);
        wdog = 1; tick(); wdog = 0;
        chk("R5 wdog off", {31'b0, smi_n}, 32'h1);
        // R6 NMI bypass
        nmi = 1; reroute = 1; tick();
        chk("R6 bypass", {31'b0, smi_n}, 32'h0);
        reroute = 0; tick(); nmi = 0;
        chk("R6 blocked", {31'b0, smi_n}, 32'h1);
        // R7 trap on both ports, other port forwarded
        wreg(32'h0000_0800, 0);
        io_v = 1; io_a = 16'h66; #1;
        chk("R7 trap 66", {31'b0, trap}, 32'h1);
        tick();
        chk("R7 smi", {31'b0, smi_n}, 32'h0);
        io_a = 16'h64; #1;
        chk("R7 fwd 64", {31'b0, fwd}, 32'h1);
        tick(); clear_events();
        // R11 APM
        wreg(32'h0000_0020, 0);
        apm = 1; tick(); apm = 0;
        chk("R11 apm on", {31'b0, smi_n}, 32'h0);
        wreg(32'h0, 0);
        apm = 1; tick(); apm = 0;
        chk("R11 apm off", {31'b0, smi_n}, 32'h1);

        // R9 timer expires exactly P0 cycles after the write
        rsel = 0;
        wreg(32'h0000_0040, 0);
        first = 0;
        for (int k = 1; k <= P0 + 2; k++) begin
            tick();
            if (tmr && first == 0) first = k;
        end
        chk("R9 first expiry", first, P0);
        // R10 cancel before expiry: no pulse afterwards
        wreg(32'h0, 0);
        wreg(32'h0000_0040, 0);
        for (int k = 0; k < P0 - 5; k++) tick();
        wreg(32'h0, 0);
        seen = 0;
        for (int k = 0; k < 2 * P1; k++) begin
            tick();
            if (tmr) seen = 1;
        end
        chk("R10 cancel", {31'b0, seen}, 32'h0);

        // random phase
        for (int c = 0; c < 6000; c++) begin
            wr_en   = ($urandom % 48) == 0;
            wr_data = $urandom;
            lock    = ($urandom % 3) == 0;
            per     = ($urandom % 16) == 0;
            wdog    = ($urandom % 16) == 0;
            nmi     = ($urandom % 16) == 0;
            reroute = ($urandom % 4) == 0;
            apm     = ($urandom % 16) == 0;
            io_v    = ($urandom % 8) == 0;
            case ($urandom % 4)
                0: io_a = 16'h62;
                1: io_a = 16'h66;
                2: io_a = 16'h60;
                default: io_a = 16'($urandom);
            endcase
            if (($urandom % 1000) == 0) rsel = ~rsel;
            tick();
        end
        clear_events();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule